// File: doc/BRIEF.md
# Serial F2 Overhead Byte Inserter

This block sits beside a mapper's serial path-overhead input and supplies one overhead byte, the F2 user-channel byte, once per frame. It runs on the mapper's overhead clock and watches two strobes from the mapper: a frame strobe and an enable strobe. When it sees both high together, it lets a fixed gap of 32 overhead-clock periods go by. That gap covers the four overhead bytes that come before F2, eight bits each. It then shifts the F2 byte out, most significant bit first. Each bit is launched on a falling edge, so the mapper can latch it on the following rising edge.

An insert qualifier is high for exactly the eight bit periods of the byte. A mapper that does not take every overhead byte from the serial port uses it to tell which bits to accept. Outside that window, the serial line is held low. The byte value comes from a register written through a simple host load port. The byte is captured when a frame window opens, so a write made while a byte is shifting only applies to the next frame. After the eighth bit, the block goes straight back to watching the strobes. A frame strobe on the very next rising edge starts a new window with no lost cycle.

Top module: `f2_serial_inserter`

## Requirements
- R1: While `rst` is high at the clock edges, `ser_data` and `ser_insert` are driven low, and the block waits for strobes after `rst` falls.
- R2: A frame window opens only on a rising edge where `poh_frame` and `poh_enable` are both high. Either strobe alone opens nothing.
- R3: Take the rising edge that opens a window as edge 0. Both outputs stay low through the falling edge that follows rising edge 31 (32 clock periods).
- R4: The byte is sent most significant bit first. Bit 7 is driven on the falling edge after rising edge 32, and each lower bit follows on the next falling edge, down to bit 0 after rising edge 39.
- R5: `ser_insert` is high for exactly the eight bit periods of the byte and low at all other times.
- R6: `ser_data` is low whenever `ser_insert` is low.
- R7: Both strobes high on rising edge 40, the edge right after the last bit is launched, open a new window at once. The new window's timing is as in R3 and R4.
- R8: Strobes seen during the gap or the shift phase have no effect on the current byte's timing or content.
- R9: A host write (`host_we` high at a rising edge, with `host_data`) sets the byte used by the next window that opens. A write during a window does not change the byte being sent.
- R10: The outputs change only on falling clock edges. Just after rising edge 32, `ser_insert` is still low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Overhead clock from the mapper |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host load strobe for the F2 value |
| host_data | input | 8 | F2 value to load |
| poh_frame | input | 1 | Frame strobe from the mapper |
| poh_enable | input | 1 | Enable strobe from the mapper |
| ser_data | output | 1 | Serial overhead data, launched on falling edges |
| ser_insert | output | 1 | High while F2 bits are on `ser_data` |

## Verification
Each fault in the state machine shows up at the ports within one frame window, 41 clock periods at most.
- An off-by-one in the gap counter moves the first rise of `ser_insert` by a whole period. It is caught on that exact falling edge.
- A wrong bit index, or a byte captured at the wrong moment, flips a data bit during the eight bit periods.
- Failing to re-arm, or reacting to a strobe in mid-window, is caught by a stray or missing qualifier in the window that follows.
- Launching on the rising edge is caught by sampling just after rising edge 32.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
  typedef enum logic [1:0] {
    PH_SAMPLE = 2'd0,
    PH_GAP    = 2'd1,
    PH_SHIFT  = 2'd2
  } phase_e;
endpackage

// File: rtl/poh_slot_seq.sv
module poh_slot_seq
  import f2i_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int GAP_BYTES = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      frame_in,
  input  logic                      enable_in,
  output phase_e                    phase,
  output logic [$clog2(BYTE_W)-1:0] bit_idx,
  output logic                      start
);
  localparam int GAP_CLKS = GAP_BYTES * BYTE_W;
  localparam int CW       = $clog2(GAP_CLKS);
  localparam int IW       = $clog2(BYTE_W);
  localparam logic [CW-1:0] GAP_LAST = CW'(GAP_CLKS - 1);
  localparam logic [IW-1:0] TOP_BIT  = IW'(BYTE_W - 1);

  logic [CW-1:0] gap_cnt;
  logic          armed;

  assign armed = frame_in && enable_in;
  // a window opens from the idle state or right after the last bit
  assign start = armed && ((phase == PH_SAMPLE) ||
                           ((phase == PH_SHIFT) && (bit_idx == '0)));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_SAMPLE;
      gap_cnt <= '0;
      bit_idx <= '0;
    end else begin
      case (phase)
        PH_SAMPLE: begin
          if (start) begin
            phase   <= PH_GAP;
            gap_cnt <= '0;
          end
        end
        PH_GAP: begin
          if (gap_cnt == GAP_LAST) begin
            phase   <= PH_SHIFT;
            bit_idx <= TOP_BIT;
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        PH_SHIFT: begin
          if (bit_idx == '0) begin
            if (start) begin
              phase   <= PH_GAP;
              gap_cnt <= '0;
            end else begin
              phase <= PH_SAMPLE;
            end
          end else begin
            bit_idx <= bit_idx - 1'b1;
          end
        end
        default: phase <= PH_SAMPLE;
      endcase
    end
  end

  p_arm_needs_both_r2: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SAMPLE && !(frame_in && enable_in)) |=> (phase == PH_SAMPLE));

  p_gap_exit_r3: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_GAP && gap_cnt == GAP_LAST) |=> (phase == PH_SHIFT && bit_idx == TOP_BIT));

  p_shift_step_r4: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SHIFT && bit_idx != '0) |=> (phase == PH_SHIFT && bit_idx == $past(bit_idx) - 1'b1));

  p_gap_ignores_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_GAP && gap_cnt != GAP_LAST) |=> (phase == PH_GAP));
endmodule

// File: rtl/poh_bit_launcher.sv
module poh_bit_launcher
  import f2i_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  phase_e                    phase,
  input  logic [$clog2(BYTE_W)-1:0] bit_idx,
  input  logic [BYTE_W-1:0]         byte_in,
  output logic                      ser_data,
  output logic                      ser_insert
);
  logic [BYTE_W-1:0] shadow;

  // the byte is frozen when a window opens
  always_ff @(posedge clk) begin
    if (rst)        shadow <= '0;
    else if (start) shadow <= byte_in;
  end

  // launch on the falling edge so the receiver samples mid-bit
  always_ff @(negedge clk) begin
    if (rst) begin
      ser_data   <= 1'b0;
      ser_insert <= 1'b0;
    end else begin
      ser_insert <= (phase == PH_SHIFT);
      ser_data   <= (phase == PH_SHIFT) ? shadow[bit_idx] : 1'b0;
    end
  end

  p_qual_window_r5: assert property (@(posedge clk) disable iff (rst)
    ser_insert == (phase == PH_SHIFT));

  p_quiet_line_r6: assert property (@(posedge clk) disable iff (rst)
    !ser_insert |-> !ser_data);

  p_shadow_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SHIFT && bit_idx != '0) |=> $stable(shadow));
endmodule

// File: rtl/f2_serial_inserter.sv
module f2_serial_inserter
  import f2i_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int GAP_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic [BYTE_W-1:0] host_data,
  input  logic              poh_frame,
  input  logic              poh_enable,
  output logic              ser_data,
  output logic              ser_insert
);
  localparam int IW = $clog2(BYTE_W);

  logic [BYTE_W-1:0] f2_hold;
  phase_e            phase;
  logic [IW-1:0]     bit_idx;
  logic              start;

  always_ff @(posedge clk) begin
    if (rst)          f2_hold <= '0;
    else if (host_we) f2_hold <= host_data;
  end

  poh_slot_seq #(.BYTE_W(BYTE_W), .GAP_BYTES(GAP_BYTES)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .frame_in  (poh_frame),
    .enable_in (poh_enable),
    .phase     (phase),
    .bit_idx   (bit_idx),
    .start     (start)
  );

  poh_bit_launcher #(.BYTE_W(BYTE_W)) u_launch (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .phase      (phase),
    .bit_idx    (bit_idx),
    .byte_in    (f2_hold),
    .ser_data   (ser_data),
    .ser_insert (ser_insert)
  );

  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!ser_insert && !ser_data));
endmodule

// File: tb/tb_f2_serial_inserter.sv
`timescale 1ns/1ps
module tb_f2_serial_inserter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_we = 1'b0;
  logic [7:0] host_data = '0;
  logic       poh_frame = 1'b0;
  logic       poh_enable = 1'b0;
  logic       ser_data;
  logic       ser_insert;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] mdl = 8'h00;

  always #2.5 clk = ~clk;

  f2_serial_inserter dut (
    .clk(clk), .rst(rst), .host_we(host_we), .host_data(host_data),
    .poh_frame(poh_frame), .poh_enable(poh_enable),
    .ser_data(ser_data), .ser_insert(ser_insert)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  function automatic logic exp_ins(input int k);
    return (k >= 32 && k <= 39);
  endfunction

  function automatic logic exp_bit(input logic [7:0] b, input int k);
    return exp_ins(k) ? b[39 - k] : 1'b0;
  endfunction

  task automatic host_write(input logic [7:0] v);
    @(posedge clk); #1 host_we = 1'b1; host_data = v;
    @(posedge clk); #1 host_we = 1'b0;
    mdl = v;
  endtask

  // one frame window; k counts falling edges after the opening rising edge
  task automatic frame(input string tag, input bit armed, input bit chain,
                       input bit noise, input bit midwrite, input logic [7:0] newval);
    logic [7:0] b;
    int last;
    last = chain ? 39 : 40;
    if (!armed) begin
      @(posedge clk); #1 poh_frame = 1'b1; poh_enable = 1'b1;
    end
    b = mdl;
    @(posedge clk); #1 poh_frame = 1'b0; poh_enable = 1'b0;
    for (int k = 0; k <= last; k++) begin
      if (k == 32) begin
        @(posedge clk); #1;
        check("R10 insert still low after rising edge 32", ser_insert, 1'b0);
      end
      @(negedge clk); #1;
      check({tag, (k < 32) ? " gap insert R3" : (k == 40) ? " post insert R5" : " insert R5"},
            ser_insert, exp_ins(k));
      check({tag, exp_ins(k) ? " data bit R4" : " idle data R6"},
            ser_data, exp_bit(b, k));
      host_we = 1'b0;
      if (midwrite && k == 34) begin
        host_we = 1'b1; host_data = newval; mdl = newval;
      end
      if (chain && k == 39) begin
        poh_frame = 1'b1; poh_enable = 1'b1;
      end else if (noise && (k == 10 || k == 35)) begin
        poh_frame = 1'b1; poh_enable = 1'b1;
      end else begin
        poh_frame = 1'b0; poh_enable = 1'b0;
      end
    end
    host_we = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    void'($urandom(32'h5EED_F2A1));
    repeat (4) @(posedge clk);
    #1;
    check("R1 reset insert", ser_insert, 1'b0);
    check("R1 reset data", ser_data, 1'b0);
    @(negedge clk); #1 rst = 1'b0;

    // R2: a single strobe never opens a window
    host_write(8'hFF);
    @(posedge clk); #1 poh_frame = 1'b1;
    repeat (5) @(posedge clk);
    #1 poh_frame = 1'b0; poh_enable = 1'b1;
    repeat (5) @(posedge clk);
    #1 poh_enable = 1'b0;
    for (int i = 0; i < 45; i++) begin
      @(negedge clk); #1;
      check("R2 lone strobe insert", ser_insert, 1'b0);
      check("R2 lone strobe data", ser_data, 1'b0);
    end

    // directed patterns
    host_write(8'hA5); frame("R4 A5", 0, 0, 0, 0, 8'h00);
    host_write(8'h80); frame("R4 80", 0, 0, 0, 0, 8'h00);
    host_write(8'h01); frame("R4 01", 0, 0, 0, 0, 8'h00);
    host_write(8'h3C); frame("R8 noisy", 0, 0, 1, 0, 8'h00);

    // R9: write during shift keeps the current byte
    host_write(8'hC3); frame("R9 old", 0, 0, 0, 1, 8'h5A);
    frame("R9 new", 0, 0, 0, 0, 8'h00);

    // R7: back-to-back windows with no idle cycle
    host_write(8'h96); frame("R7 first", 0, 1, 0, 0, 8'h00);
    frame("R7 chained", 1, 1, 0, 1, 8'h69);
    frame("R7 third", 1, 0, 0, 0, 8'h00);

    // random bytes, spacing and strobe noise
    for (int n = 0; n < 12; n++) begin
      host_write(8'($urandom_range(0, 255)));
      repeat ($urandom_range(0, 6)) @(posedge clk);
      frame("R4 rand", 0, 0, $urandom_range(0, 1) == 1, 0, 8'h00);
    end

    // R1: reset in the middle of a window silences the line
    host_write(8'hFF);
    @(posedge clk); #1 poh_frame = 1'b1; poh_enable = 1'b1;
    @(posedge clk); #1 poh_frame = 1'b0; poh_enable = 1'b0;
    repeat (34) @(posedge clk);
    #1 rst = 1'b1;
    @(posedge clk); @(negedge clk); #1;
    check("R1 mid-window reset insert", ser_insert, 1'b0);
    check("R1 mid-window reset data", ser_data, 1'b0);
    rst = 1'b0;
    mdl = 8'h00;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); #1;
      check("R1 quiet after reset", ser_insert, 1'b0);
    end
    report();
  end
endmodule